// File: doc/BRIEF.md
# Time-of-Day Counter with Fraction Alarm

This block keeps time of day as two counters: a 16-bit sub-second fraction that advances on a single-cycle tick enable, and a 32-bit count of elapsed seconds that advances each time the fraction wraps from all ones to zero. A small word-addressed slave port reaches four 32-bit registers: control/status, seconds, fraction holding and fraction alarm. Every access moves a whole 32-bit word.

Software reads the time in two steps. A read of the seconds register also copies the live fraction into the holding register. A later read of the holding register returns that copy, so a wrap between the two reads cannot mix old and new halves. A write to the seconds register loads it and restarts the fraction at zero.

The alarm compares the live fraction with the programmed alarm value on each tick while it is enabled. A match sets a sticky flag. The flag can be routed to a registered interrupt output. The block has two synchronous resets: power-on and system (watchdog or external pin). Both clear control, flag, interrupt, fraction, holding and alarm state. Neither resets the seconds counter, which is undefined after power-on.

Top module: `tod_alarm_unit`

Register word index (`rq_addr`): 0 = control/status, 1 = seconds, 2 = fraction holding, 3 = fraction alarm. Control/status layout: bit 2 alarm enable, bit 1 interrupt enable, bit 0 alarm flag.

## Requirements
- R1: While `por` or `sys_rst` is high at a clock edge, the next state has control/status 0, fraction 0, holding 0, alarm 0, `irq` 0 and `rd_data` 0.
- R2: Each cycle with `tick_en` high and no seconds write adds one to the fraction, modulo 2^16. A step from 0xFFFF to 0x0000 adds one to the seconds register.
- R3: A read of index 1 copies the current fraction into the holding register. Reads of index 2 return that copy until the next read of index 1, whatever ticks occur in between.
- R4: A write to index 1 loads the seconds register with `rq_wdata` and sets the fraction to 0 at the same edge. This takes priority over a tick in that cycle.
- R5: A `sys_rst` pulse leaves the seconds register unchanged.
- R6: Control/status bits 31:3 read as 0. Bit 0 ignores writes. Writes to index 0 set bit 2 and bit 1 from `rq_wdata[2]` and `rq_wdata[1]`.
- R7: The alarm flag sets when a cycle has `tick_en` high, alarm enable 1, and the fraction before the tick equal to the alarm register. With alarm enable 0 the flag never sets.
- R8: Only a write to index 3 clears the alarm flag. If that write falls in the same cycle as a match, the flag stays 0.
- R9: `irq` is the AND of the alarm flag and interrupt enable, delayed by one register stage. With interrupt enable 0, `irq` stays 0.
- R10: Read data appears on `rd_data` at the edge that accepts the read. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset from watchdog or external pin, synchronous, active high |
| tick_en | input | 1 | Single-cycle fraction increment enable |
| rq_valid | input | 1 | Bus access request this cycle |
| rq_write | input | 1 | 1 = write, 0 = read |
| rq_addr | input | 2 | Register word index |
| rq_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered alarm interrupt request |

## Verification
Each register update, read result and flag change is due at the edge that samples its stimulus. `irq` follows one edge after the flag and interrupt-enable state it reflects, and the holding copy is visible on the read after the seconds read that made it. The bench drives inputs on the falling edge. A behavioural model advances at each rising edge from those same inputs, and both `rd_data` and `irq` are compared 5 ns after every rising edge, so the one-cycle delay of each result is built into the comparison. Directed reads add checks against hand-worked values, such as the seconds carry after 65536 ticks and a match that coincides with an alarm write.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SECS = 2'd1,
    REG_HOLD = 2'd2,
    REG_ALRM = 2'd3
  } tod_reg_e;

  localparam int unsigned CTRL_AE_BIT  = 2;
  localparam int unsigned CTRL_AIE_BIT = 1;
  localparam int unsigned CTRL_AIF_BIT = 0;
endpackage

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned SEC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              sec_wr,
  input  logic [SEC_W-1:0]  sec_wdata,
  output logic [FRAC_W-1:0] frac_q,
  output logic [SEC_W-1:0]  sec_q
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = {FRAC_W{1'b1}};

  logic carry;
  assign carry = tick_en && (frac_q == FRAC_MAX);

  // fraction: cleared by either reset and by a seconds write
  always_ff @(posedge clk) begin
    if (rst)          frac_q <= '0;
    else if (sec_wr)  frac_q <= '0;
    else if (tick_en) frac_q <= frac_q + 1'b1;
  end

  // seconds: no reset at all, gated off while a reset is held
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (sec_wr)     sec_q <= sec_wdata;
      else if (carry) sec_q <= sec_q + 1'b1;
    end
  end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm #(
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [FRAC_W-1:0] frac_q,
  input  logic              ctrl_wr,
  input  logic              wr_ae,
  input  logic              wr_aie,
  input  logic              alarm_wr,
  input  logic [FRAC_W-1:0] alarm_wdata,
  output logic [FRAC_W-1:0] alarm_q,
  output logic              ae_q,
  output logic              aie_q,
  output logic              aif_q,
  output logic              irq_q
);
  logic hit;
  // comparator is only evaluated while enabled
  assign hit = ae_q && tick_en && (frac_q == alarm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ae_q  <= 1'b0;
      aie_q <= 1'b0;
    end else if (ctrl_wr) begin
      ae_q  <= wr_ae;
      aie_q <= wr_aie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           alarm_q <= '0;
    else if (alarm_wr) alarm_q <= alarm_wdata;
  end

  // alarm write beats a coincident match
  always_ff @(posedge clk) begin
    if (rst)           aif_q <= 1'b0;
    else if (alarm_wr) aif_q <= 1'b0;
    else if (hit)      aif_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= aif_q && aie_q;
  end
endmodule

// File: rtl/tod_bus_regs.sv
module tod_bus_regs
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rq_valid,
  input  logic              rq_write,
  input  logic [1:0]        rq_addr,
  input  logic [FRAC_W-1:0] frac_q,
  input  logic [DATA_W-1:0] sec_q,
  input  logic [FRAC_W-1:0] alarm_q,
  input  logic              ae_q,
  input  logic              aie_q,
  input  logic              aif_q,
  output logic              ctrl_wr,
  output logic              sec_wr,
  output logic              alarm_wr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - FRAC_W;

  tod_reg_e          sel;
  logic              rd_en;
  logic              wr_en;
  logic [FRAC_W-1:0] hold_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel      = tod_reg_e'(rq_addr);
  assign rd_en    = rq_valid && !rq_write;
  assign wr_en    = rq_valid && rq_write;
  assign ctrl_wr  = wr_en && (sel == REG_CTRL);
  assign sec_wr   = wr_en && (sel == REG_SECS);
  assign alarm_wr = wr_en && (sel == REG_ALRM);

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_CTRL: begin
        rd_mux[CTRL_AE_BIT]  = ae_q;
        rd_mux[CTRL_AIE_BIT] = aie_q;
        rd_mux[CTRL_AIF_BIT] = aif_q;
      end
      REG_SECS: rd_mux = sec_q;
      REG_HOLD: rd_mux = {{PAD_W{1'b0}}, hold_q};
      REG_ALRM: rd_mux = {{PAD_W{1'b0}}, alarm_q};
      default:  rd_mux = '0;
    endcase
  end

  // snapshot of the fraction taken with every seconds read
  always_ff @(posedge clk) begin
    if (rst)                           hold_q <= '0;
    else if (rd_en && sel == REG_SECS) hold_q <= frac_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              sys_rst,
  input  logic              tick_en,
  input  logic              rq_valid,
  input  logic              rq_write,
  input  logic [1:0]        rq_addr,
  input  logic [DATA_W-1:0] rq_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic              rst;
  logic              ctrl_wr;
  logic              sec_wr;
  logic              alarm_wr;
  logic [FRAC_W-1:0] frac_q;
  logic [DATA_W-1:0] sec_q;
  logic [FRAC_W-1:0] alarm_q;
  logic              ae_q;
  logic              aie_q;
  logic              aif_q;

  assign rst = por || sys_rst;

  tod_counter #(.FRAC_W(FRAC_W), .SEC_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .sec_wr(sec_wr), .sec_wdata(rq_wdata),
    .frac_q(frac_q), .sec_q(sec_q)
  );

  tod_alarm #(.FRAC_W(FRAC_W)) u_alm (
    .clk(clk), .rst(rst), .tick_en(tick_en), .frac_q(frac_q),
    .ctrl_wr(ctrl_wr), .wr_ae(rq_wdata[CTRL_AE_BIT]), .wr_aie(rq_wdata[CTRL_AIE_BIT]),
    .alarm_wr(alarm_wr), .alarm_wdata(rq_wdata[FRAC_W-1:0]),
    .alarm_q(alarm_q), .ae_q(ae_q), .aie_q(aie_q), .aif_q(aif_q), .irq_q(irq)
  );

  tod_bus_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_bus (
    .clk(clk), .rst(rst), .rq_valid(rq_valid), .rq_write(rq_write), .rq_addr(rq_addr),
    .frac_q(frac_q), .sec_q(sec_q), .alarm_q(alarm_q),
    .ae_q(ae_q), .aie_q(aie_q), .aif_q(aif_q),
    .ctrl_wr(ctrl_wr), .sec_wr(sec_wr), .alarm_wr(alarm_wr), .rd_data(rd_data)
  );
endmodule

// File: rtl/tod_alarm_unit_chk.sv
module tod_alarm_unit_chk
  import tod_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 16
) (
  input logic              clk,
  input logic              por,
  input logic              sys_rst,
  input logic              tick_en,
  input logic              rq_valid,
  input logic              rq_write,
  input logic [1:0]        rq_addr,
  input logic [DATA_W-1:0] rq_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [FRAC_W-1:0] frac_q,
  input logic [DATA_W-1:0] sec_q,
  input logic              ae_q,
  input logic              aie_q,
  input logic              aif_q
);
  logic              any_rst;
  logic              sec_wr;
  logic              alm_wr;
  logic              ctrl_rd;
  logic              carry;
  logic              sec_valid;
  logic [FRAC_W-1:0] frac_inc;
  logic [DATA_W-1:0] sec_inc;

  assign any_rst  = por || sys_rst;
  assign sec_wr   = rq_valid && rq_write && (rq_addr == 2'd1);
  assign alm_wr   = rq_valid && rq_write && (rq_addr == 2'd3);
  assign ctrl_rd  = rq_valid && !rq_write && (rq_addr == 2'd0);
  assign carry    = tick_en && (&frac_q);
  assign frac_inc = frac_q + 1'b1;
  assign sec_inc  = sec_q + 1'b1;

  always_ff @(posedge clk) begin
    if (por)         sec_valid <= 1'b0;
    else if (sec_wr && !sys_rst) sec_valid <= 1'b1;
  end

  assert_frac_step_R2: assert property (@(posedge clk) disable iff (any_rst)
    (tick_en && !sec_wr) |=> frac_q == $past(frac_inc));
  assert_sec_carry_R2: assert property (@(posedge clk) disable iff (any_rst)
    (carry && !sec_wr && sec_valid) |=> sec_q == $past(sec_inc));
  assert_sec_load_R4: assert property (@(posedge clk) disable iff (any_rst)
    sec_wr |=> (frac_q == '0) && (sec_q == $past(rq_wdata)));
  assert_sec_keep_R5: assert property (@(posedge clk) disable iff (por)
    (sys_rst && sec_valid) |=> sec_q == $past(sec_q));
  assert_ctrl_hi_zero_R6: assert property (@(posedge clk) disable iff (any_rst)
    ctrl_rd |=> rd_data[DATA_W-1:3] == '0);
  assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (any_rst)
    $rose(aif_q) |-> ($past(ae_q) && $past(tick_en)));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (any_rst)
    (aif_q && !alm_wr) |=> aif_q);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (any_rst)
    alm_wr |=> !aif_q);
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (any_rst)
    !aie_q |=> !irq);
endmodule

bind tod_alarm_unit tod_alarm_unit_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .por(por), .sys_rst(sys_rst), .tick_en(tick_en),
  .rq_valid(rq_valid), .rq_write(rq_write), .rq_addr(rq_addr), .rq_wdata(rq_wdata),
  .rd_data(rd_data), .irq(irq), .frac_q(frac_q), .sec_q(sec_q),
  .ae_q(ae_q), .aie_q(aie_q), .aif_q(aif_q)
);

// File: tb/tod_alarm_unit_tb_top.sv
module tod_alarm_unit_tb_top;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        sys_rst = 1'b0;
  logic        tick = 1'b0;
  logic        rv = 1'b0;
  logic        rw = 1'b0;
  logic [1:0]  ra = 2'd0;
  logic [31:0] rd_d = 32'd0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tod_alarm_unit dut_i (
    .clk(clk), .por(por), .sys_rst(sys_rst), .tick_en(tick),
    .rq_valid(rv), .rq_write(rw), .rq_addr(ra), .rq_wdata(rd_d),
    .rd_data(rd_data), .irq(irq)
  );

  // behavioural reference model
  int unsigned m_frac = 0, m_hold = 0, m_alarm = 0, m_sec = 0, m_rd = 0;
  bit m_ae = 0, m_aie = 0, m_aif = 0, m_irq = 0;
  bit m_sec_known = 0, m_rd_known = 1;

  always @(posedge clk) begin
    if (por || sys_rst) begin
      m_frac = 0; m_hold = 0; m_alarm = 0; m_rd = 0; m_rd_known = 1;
      m_ae = 0; m_aie = 0; m_aif = 0; m_irq = 0;
      if (por) m_sec_known = 0;
    end else begin
      int unsigned o_frac;
      bit o_aif, o_aie;
      o_frac = m_frac; o_aif = m_aif; o_aie = m_aie;
      if (rv && !rw) begin
        case (ra)
          2'd0: begin m_rd = {29'd0, m_ae, m_aie, m_aif}; m_rd_known = 1; end
          2'd1: begin m_rd = m_sec; m_rd_known = m_sec_known; m_hold = o_frac; end
          2'd2: begin m_rd = m_hold; m_rd_known = 1; end
          default: begin m_rd = m_alarm; m_rd_known = 1; end
        endcase
      end
      if (rv && rw && ra == 2'd3) m_aif = 0;
      else if (m_ae && tick && o_frac == m_alarm) m_aif = 1;
      if (rv && rw && ra == 2'd1) begin
        m_sec = rd_d; m_frac = 0; m_sec_known = 1;
      end else if (tick) begin
        m_frac = (o_frac + 1) % 65536;
        if (o_frac == 65535) m_sec = m_sec + 1;
      end
      if (rv && rw && ra == 2'd0) begin m_ae = rd_d[2]; m_aie = rd_d[1]; end
      if (rv && rw && ra == 2'd3) m_alarm = rd_d & 32'hFFFF;
      m_irq = o_aif && o_aie;
    end
  end

  // per-clock comparison away from the edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      if (m_rd_known) begin
        checks++;
        if (rd_data !== m_rd) begin
          fails++;
          $display("FAIL %s rd_data act %h exp %h at %0t", cur_req, rd_data, m_rd, $time);
        end
      end
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq act %0b exp %0b at %0t", cur_req, irq, m_irq, $time);
      end
    end
  end

  task automatic drive(input bit v, input bit w, input logic [1:0] a,
                       input logic [31:0] d, input bit t);
    @(negedge clk);
    rv = v; rw = w; ra = a; rd_d = d; tick = t;
  endtask

  task automatic idle(); drive(0, 0, 2'd0, 32'd0, 0); endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d); drive(1, 1, a, d, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 2'd0, 32'd0, 1);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    drive(1, 0, a, 32'd0, 0);
    @(posedge clk); #5;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s directed read idx %0d act %h exp %h", req, a, rd_data, exp);
    end
  endtask

  task automatic summary();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act running exp finished");
    summary();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    por = 1'b0;
    rd_chk(2'd0, 32'd0, "R1");
    rd_chk(2'd2, 32'd0, "R1");
    rd_chk(2'd3, 32'd0, "R1");
    // R10: data appears at the accepting edge and holds
    cur_req = "R10";
    wr(2'd3, 32'h0000_00A5);
    rd_chk(2'd3, 32'h0000_00A5, "R10");
    idle(); idle();
    @(posedge clk); #5;
    checks++;
    if (rd_data !== 32'h0000_00A5) begin
      fails++; $display("FAIL R10 held read act %h exp %h", rd_data, 32'h0000_00A5);
    end
    // R4: seconds write with a coincident tick
    cur_req = "R4";
    drive(1, 1, 2'd1, 32'h1234_0000, 1);
    rd_chk(2'd1, 32'h1234_0000, "R4");
    rd_chk(2'd2, 32'd0, "R4");
    // R2: fraction steps
    cur_req = "R2";
    ticks(10);
    rd_chk(2'd1, 32'h1234_0000, "R2");
    rd_chk(2'd2, 32'd10, "R2");
    // R3: snapshot survives further ticks
    cur_req = "R3";
    ticks(5);
    rd_chk(2'd2, 32'd10, "R3");
    rd_chk(2'd1, 32'h1234_0000, "R3");
    rd_chk(2'd2, 32'd15, "R3");
    // R2: carry into seconds
    cur_req = "R2";
    wr(2'd1, 32'd7);
    ticks(65535);
    rd_chk(2'd1, 32'd7, "R2");
    rd_chk(2'd2, 32'hFFFF, "R2");
    ticks(1);
    rd_chk(2'd1, 32'd8, "R2");
    rd_chk(2'd2, 32'd0, "R2");
    // R6: upper bits zero, flag bit not writable
    cur_req = "R6";
    wr(2'd0, 32'hFFFF_FFF9);
    rd_chk(2'd0, 32'd0, "R6");
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk(2'd0, 32'h6, "R6");
    // R7: no flag while disabled, flag once enabled
    cur_req = "R7";
    wr(2'd0, 32'd0);
    wr(2'd3, 32'd3);
    wr(2'd1, 32'd0);
    ticks(6);
    rd_chk(2'd0, 32'd0, "R7");
    wr(2'd0, 32'h4);
    wr(2'd1, 32'd0);
    ticks(6);
    rd_chk(2'd0, 32'h5, "R7");
    // R9: masked, then enabled interrupt
    cur_req = "R9";
    idle(); idle();
    wr(2'd0, 32'h6);
    idle(); idle();
    checks++;
    if (irq !== 1'b1) begin
      fails++; $display("FAIL R9 irq act %0b exp 1", irq);
    end
    // R8: sticky, cleared by alarm write, write beats match
    cur_req = "R8";
    wr(2'd0, 32'h6);
    rd_chk(2'd0, 32'h7, "R8");
    wr(2'd3, 32'd3);
    idle(); idle();
    rd_chk(2'd0, 32'h6, "R8");
    wr(2'd1, 32'd0);
    ticks(3);
    drive(1, 1, 2'd3, 32'd3, 1);
    idle();
    rd_chk(2'd0, 32'h6, "R8");
    // R5: seconds survive a system reset
    cur_req = "R5";
    wr(2'd1, 32'h0000_ABCD);
    ticks(4);
    @(negedge clk); sys_rst = 1'b1; rv = 0; rw = 0; tick = 0;
    @(negedge clk); sys_rst = 1'b0;
    rd_chk(2'd1, 32'h0000_ABCD, "R5");
    rd_chk(2'd2, 32'd0, "R5");
    rd_chk(2'd0, 32'd0, "R1");
    idle(); idle();
    summary();
  end
endmodule